// File: doc/BRIEF.md
# Parallel RGB Display Output Formatter

This block sits between a display timing generator and a parallel panel. Each clock it accepts one 24-bit RGB pixel together with horizontal sync, vertical sync and data-enable. It reorders the three colour channels and packs the result onto 24 panel data lines using one of seven fixed bus layouts. It then drives the panel's sync, data-enable and pixel clock outputs, each with its own polarity and launch-edge control. Horizontal sync, vertical sync and data-enable can each also be switched off.

All behaviour comes from one control word reached through a small register read/write port. A read at any offset other than zero returns a fixed identification word that software can use to confirm the block is present. The block clock is the pixel clock. The pixel clock output is that clock, optionally inverted.

While the enable bit is clear, the pipeline is held cleared and every output is driven low. Raising the enable bit therefore always starts from a fully reset state.

Top module: `rgb_bus_formatter`

## Requirements
- R1: A write with `reg_we` at offset 0 loads bits 16:0 of `reg_wdata` into the control word. A read with `reg_re` at offset 0 returns the control word in bits 16:0 and zeros above, on `reg_rdata` one clock after the strobe. A read in the same cycle as a write returns the old value.
- R2: A read at any non-zero offset returns 0x00647069. Writes to non-zero offsets change nothing.
- R3: Control bit 0 is the enable. While it is 0, all outputs (data, syncs, data-enable, pixel clock) are low and the pipeline is held cleared. After it rises, the outputs show the idle state (data zero, each control at its inactive level) until the first pixel has been registered.
- R4: Control bits 15:14 pick the channel order. Input bits 23:16 are R, 15:8 are G and 7:0 are B. The codes fill slots (first, second, third) as follows: 0 gives (R,G,B), 1 gives (B,G,R), 2 gives (G,R,B) and 3 gives (B,R,G).
- R5: Control bits 13:11 pick the packing. Codes 0 and 7 drive all zeros. The 5-6-5 codes use the top 5, 6 and 5 bits of the first, second and third slot. Code 1 places them at [15:11], [10:5] and [4:0]. Code 2 places them at [20:16], [13:8] and [4:0]. Code 3 places them at [21:17], [13:8] and [5:1]. All other data bits are zero.
- R6: The 6-6-6 codes use the top 6 bits of each slot. Code 4 places them at [17:12], [11:6] and [5:0]. Code 5 places them at [21:16], [13:8] and [5:0]. Code 6 places the full slots at [23:16], [15:8] and [7:0]. All other data bits are zero.
- R7: Bit 10 inverts the pixel clock output. Bits 9, 8 and 7 invert horizontal sync, vertical sync and data-enable respectively.
- R8: Bits 6, 5 and 4 make horizontal sync, vertical sync and data-enable change on the falling clock edge instead of the rising edge. This delays each of them by half a clock.
- R9: Bits 3, 2 and 1 switch off horizontal sync, vertical sync and data-enable respectively. A switched-off signal is forced to 0 before inversion, so its output equals its invert bit.
- R10: Pixel data and rising-launched controls appear one clock after the input is sampled, aligned with each other. Order, packing and switch-off settings apply from the first pixel registered after they are written. Invert, launch-edge and enable settings act on the outputs at once.
- R11: Bit 16 is a stored mode bit. It reads back but does not affect any output.
- R12: Synchronous active-high `rst` clears the control word, the pipeline and `reg_rdata`, so that all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; all state runs on it |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, valid one clock after `reg_re` |
| pix_rgb | input | 24 | Incoming pixel, R in 23:16, G in 15:8, B in 7:0 |
| pix_hs | input | 1 | Incoming horizontal sync, active high |
| pix_vs | input | 1 | Incoming vertical sync, active high |
| pix_de | input | 1 | Incoming data-enable, active high |
| bus_data | output | 24 | Packed panel data lines |
| bus_hs | output | 1 | Panel horizontal sync |
| bus_vs | output | 1 | Panel vertical sync |
| bus_de | output | 1 | Panel data-enable |
| bus_pclk | output | 1 | Panel pixel clock |

## Verification
The assertions assume that `rst` is held for at least two clocks at start-up, so that the control word is known before any check looks one cycle back. They also assume that pixel and sync inputs change only away from the rising edge, and that register strobes are single-cycle. The bench drives all inputs a quarter period after each rising edge, well before the falling edge at which the half-cycle launch registers capture. It pulses strobes for exactly one clock, and asserts reset for three clocks at start and two in the middle of the run. Sync and data-enable inputs come from a pseudo-random sequence, so they toggle freely while each mode is active.

// File: rtl/rgbfmt_pkg.sv
`timescale 1ns/1ps
package rgbfmt_pkg;
  localparam int CH_W   = 8;
  localparam int PIX_W  = 3 * CH_W;
  localparam int NSIG   = 3;
  localparam int CTRL_W = 17;

  // index of each control signal within the per-signal vectors
  localparam int SIG_DE = 0;
  localparam int SIG_VS = 1;
  localparam int SIG_HS = 2;

  typedef enum logic [1:0] {
    ORD_RGB = 2'd0,
    ORD_BGR = 2'd1,
    ORD_GRB = 2'd2,
    ORD_BRG = 2'd3
  } order_e;

  typedef enum logic [2:0] {
    PK_ZERO       = 3'd0,
    PK_565_LOW    = 3'd1,
    PK_565_SPREAD = 3'd2,
    PK_565_SHIFT  = 3'd3,
    PK_666_LOW    = 3'd4,
    PK_666_SPREAD = 3'd5,
    PK_888        = 3'd6,
    PK_RSVD       = 3'd7
  } pack_e;

  // control word, most significant field first (bit 16 down to bit 0)
  typedef struct packed {
    logic            mode_bit;
    order_e          order;
    pack_e           pack;
    logic            pclk_inv;
    logic [NSIG-1:0] inv;
    logic [NSIG-1:0] fall;
    logic [NSIG-1:0] off;
    logic            en;
  } ctrl_t;

  typedef struct packed {
    logic [NSIG-1:0]  ctl;
    logic [PIX_W-1:0] data;
  } stage_t;
endpackage

// File: rtl/rgbfmt_regs.sv
`timescale 1ns/1ps
module rgbfmt_regs
  import rgbfmt_pkg::*;
#(
  parameter int              ADDR_W  = 6,
  parameter int              DATA_W  = 32,
  parameter logic [DATA_W-1:0] ID_WORD = 32'h0064_7069
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output ctrl_t             ctrl
);
  localparam logic [ADDR_W-1:0] CTRL_OFS = '0;
  localparam int PAD_W = DATA_W - CTRL_W;

  logic hit_ctrl;
  logic unused_wdata_hi;

  assign hit_ctrl        = (reg_addr == CTRL_OFS);
  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:CTRL_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl      <= '0;
      reg_rdata <= '0;
    end else begin
      if (reg_we && hit_ctrl)
        ctrl <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
      if (reg_re)
        reg_rdata <= hit_ctrl ? {{PAD_W{1'b0}}, ctrl} : ID_WORD;
    end
  end
endmodule

// File: rtl/rgbfmt_shuffle.sv
`timescale 1ns/1ps
module rgbfmt_shuffle
  import rgbfmt_pkg::*;
(
  input  logic [PIX_W-1:0] pix_in,
  input  order_e           order,
  output logic [PIX_W-1:0] slots
);
  logic [CH_W-1:0] red, grn, blu;

  assign red = pix_in[3*CH_W-1 -: CH_W];
  assign grn = pix_in[2*CH_W-1 -: CH_W];
  assign blu = pix_in[CH_W-1 -: CH_W];

  always_comb begin
    unique case (order)
      ORD_RGB: slots = {red, grn, blu};
      ORD_BGR: slots = {blu, grn, red};
      ORD_GRB: slots = {grn, red, blu};
      ORD_BRG: slots = {blu, red, grn};
      default: slots = {red, grn, blu};
    endcase
  end
endmodule

// File: rtl/rgbfmt_pack.sv
`timescale 1ns/1ps
module rgbfmt_pack
  import rgbfmt_pkg::*;
(
  input  logic [PIX_W-1:0] slots,
  input  pack_e            mode,
  output logic [PIX_W-1:0] lines
);
  logic [CH_W-1:0] s0, s1, s2;
  logic [4:0] s0_5, s2_5;
  logic [5:0] s0_6, s1_6, s2_6;

  assign s0 = slots[3*CH_W-1 -: CH_W];
  assign s1 = slots[2*CH_W-1 -: CH_W];
  assign s2 = slots[CH_W-1 -: CH_W];

  // reduced fields always keep the most significant bits of a channel
  assign s0_5 = s0[CH_W-1 -: 5];
  assign s2_5 = s2[CH_W-1 -: 5];
  assign s0_6 = s0[CH_W-1 -: 6];
  assign s1_6 = s1[CH_W-1 -: 6];
  assign s2_6 = s2[CH_W-1 -: 6];

  always_comb begin
    unique case (mode)
      PK_565_LOW:    lines = {8'd0, s0_5, s1_6, s2_5};
      PK_565_SPREAD: lines = {3'd0, s0_5, 2'd0, s1_6, 3'd0, s2_5};
      PK_565_SHIFT:  lines = {2'd0, s0_5, 3'd0, s1_6, 2'd0, s2_5, 1'b0};
      PK_666_LOW:    lines = {6'd0, s0_6, s1_6, s2_6};
      PK_666_SPREAD: lines = {2'd0, s0_6, 2'd0, s1_6, 2'd0, s2_6};
      PK_888:        lines = {s0, s1, s2};
      default:       lines = '0;
    endcase
  end
endmodule

// File: rtl/rgbfmt_sigout.sv
`timescale 1ns/1ps
module rgbfmt_sigout (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic early,
  input  logic use_late,
  input  logic invert,
  output logic pin
);
  logic late_q;

  // half-cycle delayed copy, launched on the falling edge
  always_ff @(negedge clk) begin
    if (rst) late_q <= 1'b0;
    else     late_q <= early;
  end

  assign pin = en & ((use_late ? late_q : early) ^ invert);
endmodule

// File: rtl/rgb_bus_formatter.sv
`timescale 1ns/1ps
module rgb_bus_formatter
  import rgbfmt_pkg::*;
#(
  parameter int                ADDR_W  = 6,
  parameter int                DATA_W  = 32,
  parameter logic [DATA_W-1:0] ID_WORD = 32'h0064_7069
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [PIX_W-1:0]  pix_rgb,
  input  logic              pix_hs,
  input  logic              pix_vs,
  input  logic              pix_de,
  output logic [PIX_W-1:0]  bus_data,
  output logic              bus_hs,
  output logic              bus_vs,
  output logic              bus_de,
  output logic              bus_pclk
);
  ctrl_t            ctrl_q;
  logic [PIX_W-1:0] slot_pix;
  logic [PIX_W-1:0] packed_pix;
  stage_t           stage_d, stage_q;
  logic [NSIG-1:0]  raw_ctl;
  logic [NSIG-1:0]  ctl_pins;
  logic             unused_mode;

  assign unused_mode = ctrl_q.mode_bit;

  rgbfmt_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .ID_WORD(ID_WORD)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .reg_we   (reg_we),
    .reg_re   (reg_re),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .ctrl     (ctrl_q)
  );

  rgbfmt_shuffle u_shuffle (
    .pix_in(pix_rgb),
    .order (ctrl_q.order),
    .slots (slot_pix)
  );

  rgbfmt_pack u_pack (
    .slots(slot_pix),
    .mode (ctrl_q.pack),
    .lines(packed_pix)
  );

  always_comb begin
    raw_ctl         = '0;
    raw_ctl[SIG_HS] = pix_hs;
    raw_ctl[SIG_VS] = pix_vs;
    raw_ctl[SIG_DE] = pix_de;
    stage_d.data    = packed_pix;
    stage_d.ctl     = raw_ctl & ~ctrl_q.off;
  end

  // single pipeline stage; held cleared whenever the block is off
  always_ff @(posedge clk) begin
    if (rst || !ctrl_q.en) stage_q <= '0;
    else                   stage_q <= stage_d;
  end

  for (genvar i = 0; i < NSIG; i++) begin : g_sig
    rgbfmt_sigout u_sig (
      .clk     (clk),
      .rst     (rst),
      .en      (ctrl_q.en),
      .early   (stage_q.ctl[i]),
      .use_late(ctrl_q.fall[i]),
      .invert  (ctrl_q.inv[i]),
      .pin     (ctl_pins[i])
    );
  end

  assign bus_hs   = ctl_pins[SIG_HS];
  assign bus_vs   = ctl_pins[SIG_VS];
  assign bus_de   = ctl_pins[SIG_DE];
  assign bus_data = ctrl_q.en ? stage_q.data : '0;
  assign bus_pclk = ctrl_q.en & (clk ^ ctrl_q.pclk_inv);
endmodule

// File: rtl/rgbfmt_chk.sv
`timescale 1ns/1ps
module rgbfmt_chk
  import rgbfmt_pkg::*;
#(
  parameter int                ADDR_W  = 6,
  parameter int                DATA_W  = 32,
  parameter logic [DATA_W-1:0] ID_WORD = 32'h0064_7069
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_re,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [PIX_W-1:0]  pix_rgb,
  input logic [PIX_W-1:0]  bus_data,
  input logic              bus_hs,
  input logic              bus_vs,
  input logic              bus_de,
  input logic              bus_pclk,
  input ctrl_t             ctrl_bits
);
  localparam int PAD_W = DATA_W - CTRL_W;

  assert_ctrl_readback_R1: assert property (@(posedge clk) disable iff (rst)
    (reg_re && reg_addr == '0) |=> reg_rdata == {{PAD_W{1'b0}}, $past(ctrl_bits)});

  assert_id_word_R2: assert property (@(posedge clk) disable iff (rst)
    (reg_re && reg_addr != '0) |=> reg_rdata == ID_WORD);

  assert_idle_low_R3: assert property (@(posedge clk) disable iff (rst)
    !ctrl_bits.en |-> (bus_data == '0 && !bus_hs && !bus_vs && !bus_de && !bus_pclk));

  assert_swap_order_R4: assert property (@(posedge clk) disable iff (rst)
    (ctrl_bits.en && $past(ctrl_bits.en) && !$past(rst) &&
     $past(ctrl_bits.pack) == PK_888 && $past(ctrl_bits.order) == ORD_BGR)
    |-> bus_data == {$past(pix_rgb[7:0]), $past(pix_rgb[15:8]), $past(pix_rgb[23:16])});

  assert_zero_pack_R5: assert property (@(posedge clk) disable iff (rst)
    (ctrl_bits.en && $past(ctrl_bits.en) && $past(ctrl_bits.pack) == PK_ZERO)
    |-> bus_data == '0);

  assert_pass_through_R10: assert property (@(posedge clk) disable iff (rst)
    (ctrl_bits.en && $past(ctrl_bits.en) && !$past(rst) &&
     $past(ctrl_bits.pack) == PK_888 && $past(ctrl_bits.order) == ORD_RGB)
    |-> bus_data == $past(pix_rgb));

  assert_hs_switched_off_R9: assert property (@(posedge clk) disable iff (rst)
    (ctrl_bits.en && $past(ctrl_bits.off[SIG_HS]) && $past(ctrl_bits.en))
    |-> bus_hs == ctrl_bits.inv[SIG_HS]);
endmodule

bind rgb_bus_formatter rgbfmt_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .ID_WORD(ID_WORD)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .reg_re   (reg_re),
  .reg_addr (reg_addr),
  .reg_rdata(reg_rdata),
  .pix_rgb  (pix_rgb),
  .bus_data (bus_data),
  .bus_hs   (bus_hs),
  .bus_vs   (bus_vs),
  .bus_de   (bus_de),
  .bus_pclk (bus_pclk),
  .ctrl_bits(ctrl_q)
);

// File: tb/sim_rgb_bus_formatter.sv
`timescale 1ns/1ps
module sim_rgb_bus_formatter;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam logic [31:0] ID = 32'h0064_7069;
  localparam int EN = 1;

  logic clk = 1'b0;
  logic rst, reg_we, reg_re;
  logic [AW-1:0] reg_addr;
  logic [DW-1:0] reg_wdata, reg_rdata;
  logic [23:0] pix_rgb, bus_data;
  logic pix_hs, pix_vs, pix_de, bus_hs, bus_vs, bus_de, bus_pclk;

  always #10 clk = ~clk;

  rgb_bus_formatter u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pix_rgb(pix_rgb), .pix_hs(pix_hs), .pix_vs(pix_vs), .pix_de(pix_de),
    .bus_data(bus_data), .bus_hs(bus_hs), .bus_vs(bus_vs), .bus_de(bus_de),
    .bus_pclk(bus_pclk)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_req = "R12";
  int unsigned seed = 32'h1234_5678;

  // reference state
  logic [16:0] m_ctrl = '0;
  logic [23:0] m_data = '0;
  logic [2:0]  m_ctl = '0;   // {hs, vs, de} as registered
  logic [2:0]  m_prev = '0;  // same, one clock older

  function automatic logic [23:0] ref_fmt(input logic [1:0] ord, input logic [2:0] f,
                                          input logic [23:0] p);
    int r, g, b, a0, a1, a2;
    logic [31:0] v;
    r = int'(p[23:16]); g = int'(p[15:8]); b = int'(p[7:0]);
    case (ord)
      2'd0: begin a0 = r; a1 = g; a2 = b; end
      2'd1: begin a0 = b; a1 = g; a2 = r; end
      2'd2: begin a0 = g; a1 = r; a2 = b; end
      default: begin a0 = b; a1 = r; a2 = g; end
    endcase
    case (f)
      3'd1: v = 32'((a0 / 8) * 2048 + (a1 / 4) * 32 + (a2 / 8));
      3'd2: v = 32'((a0 / 8) * 65536 + (a1 / 4) * 256 + (a2 / 8));
      3'd3: v = 32'((a0 / 8) * 131072 + (a1 / 4) * 256 + (a2 / 8) * 2);
      3'd4: v = 32'((a0 / 4) * 4096 + (a1 / 4) * 64 + (a2 / 4));
      3'd5: v = 32'((a0 / 4) * 65536 + (a1 / 4) * 256 + (a2 / 4));
      3'd6: v = 32'(a0 * 65536 + a1 * 256 + a2);
      default: v = 0;
    endcase
    return v[23:0];
  endfunction

  task automatic new_pixel();
    seed = seed * 32'd1103515245 + 32'd12345;
    pix_rgb = seed[31:8];
    pix_hs = seed[3];
    pix_vs = seed[5];
    pix_de = seed[7];
  endtask

  task automatic tick();
    logic [16:0] c_old;
    logic [23:0] n_data;
    logic [2:0]  n_ctl;
    logic [31:0] exp_rd;
    logic [27:0] exp_out, got_out;
    bit rd_chk;
    c_old = m_ctrl;
    if (rst || !c_old[0]) begin
      n_data = '0; n_ctl = '0;
    end else begin
      n_data = ref_fmt(c_old[15:14], c_old[13:11], pix_rgb);
      n_ctl = {pix_hs & ~c_old[3], pix_vs & ~c_old[2], pix_de & ~c_old[1]};
    end
    rd_chk = 0; exp_rd = '0;
    if (!rst && reg_re) begin
      rd_chk = 1;
      exp_rd = (reg_addr == '0) ? {15'd0, c_old} : ID;
    end
    if (rst) m_ctrl = '0;
    else if (reg_we && reg_addr == '0) m_ctrl = reg_wdata[16:0];
    @(posedge clk);
    m_prev = m_ctl; m_ctl = n_ctl; m_data = n_data;
    #5;
    if (!m_ctrl[0]) exp_out = '0;
    else begin
      exp_out[23:0] = m_data;
      for (int i = 0; i < 3; i++)
        exp_out[24 + i] = (m_ctrl[4 + i] ? m_prev[i] : m_ctl[i]) ^ m_ctrl[7 + i];
      exp_out[27] = ~m_ctrl[10];  // clock is high at this sample point
    end
    got_out = {bus_pclk, bus_hs, bus_vs, bus_de, bus_data};
    checks++;
    if (got_out !== exp_out) begin
      errors++;
      $display("FAIL %s outputs {pclk,hs,vs,de,data} got %h expected %h", cur_req, got_out, exp_out);
    end
    if (rd_chk) begin
      checks++;
      if (reg_rdata !== exp_rd) begin
        errors++;
        $display("FAIL %s rdata got %h expected %h", cur_req, reg_rdata, exp_rd);
      end
    end
    new_pixel();
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 0; reg_addr = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a);
    reg_re = 1; reg_addr = a;
    tick();
    reg_re = 0; reg_addr = '0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired got running expected finished");
    finish_up();
  end

  initial begin
    rst = 1; reg_we = 0; reg_re = 0; reg_addr = '0; reg_wdata = '0;
    new_pixel();
    // R12: reset state
    cur_req = "R12";
    run(3);
    rst = 0;
    run(2);
    rd(0);
    // R2: identification word, ignored writes
    cur_req = "R2";
    rd(6'h04);
    rd(6'h3C);
    wr(6'h08, 32'h0001_FFFF);
    run(2);
    rd(0);
    // R10: straight 8-8-8 path and latency
    cur_req = "R10";
    wr(0, EN | (6 << 11));
    run(20);
    // R4: each channel order
    cur_req = "R4";
    for (int o = 0; o < 4; o++) begin
      wr(0, EN | (6 << 11) | (o << 14));
      run(10);
    end
    // R5 / R6: every packing code, two orders
    for (int f = 0; f < 8; f++) begin
      cur_req = (f >= 4 && f <= 6) ? "R6" : "R5";
      wr(0, EN | (f << 11));
      run(8);
      wr(0, EN | (f << 11) | (3 << 14));
      run(8);
    end
    // R7: inversions
    cur_req = "R7";
    wr(0, EN | (6 << 11) | (32'hF << 7));
    run(10);
    wr(0, EN | (6 << 11) | (1 << 10));
    run(6);
    // R8: falling-edge launch, plain then inverted
    cur_req = "R8";
    wr(0, EN | (6 << 11) | (7 << 4));
    run(12);
    wr(0, EN | (6 << 11) | (7 << 4) | (7 << 7));
    run(12);
    wr(0, EN | (6 << 11) | (1 << 6));
    run(8);
    // R9: switch-off, with and without inversion
    cur_req = "R9";
    wr(0, EN | (6 << 11) | (7 << 1));
    run(8);
    wr(0, EN | (6 << 11) | (7 << 1) | (5 << 7));
    run(8);
    wr(0, EN | (6 << 11) | (1 << 3) | (1 << 6) | (1 << 9));
    run(8);
    // R11: mode bit has no effect
    cur_req = "R11";
    wr(0, EN | (1 << 16) | (6 << 11) | (1 << 14));
    run(10);
    // R1: readback of the control word, read together with a write
    cur_req = "R1";
    rd(0);
    reg_re = 1; reg_we = 1; reg_addr = '0; reg_wdata = EN | (5 << 11) | (2 << 14);
    tick();
    reg_re = 0; reg_we = 0;
    rd(0);
    run(4);
    // R3: disable mid-stream, stay off, re-enable
    cur_req = "R3";
    wr(0, (6 << 11) | (32'hF << 7));
    run(8);
    wr(0, EN | (6 << 11) | (32'hF << 7) | (7 << 4));
    run(10);
    // R12: reset in the middle of a run
    cur_req = "R12";
    rst = 1;
    run(2);
    rst = 0;
    run(3);
    rd(0);
    finish_up();
  end
endmodule